// File: doc/BRIEF.md
# Interrupt Coalescing Moderator

This block sits between a stream of single-cycle device event pulses, such as completed receive frames, and one level interrupt line. It does not interrupt for every event. It gathers events into a batch and raises the interrupt once, when whichever of two limits is hit first: the batch reaches a programmed event count, or a programmed time budget in microseconds runs out after the first event of the batch. A larger event count or a longer budget gives fewer interrupts but more waiting per event. Small values favour latency.

A prescaler divides the core clock down to a one-microsecond tick. The timer runs only while at least one event is waiting to be reported. When the interrupt is raised, the current batch is closed and counting starts over. Events that arrive while the interrupt is still waiting for its acknowledge go into the next batch. The acknowledge input drops the interrupt line.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `irq_o` is low and no events are outstanding.
- R2: When the outstanding event count, sampled at a clock edge, is non-zero and at least `frame_thr_i`, and `irq_o` is low, `irq_o` is high after the next edge. A threshold of 0 acts as 1.
- R3: When the count threshold is not reached, `irq_o` rises `time_budget_i * TICK_DIV + 1` clock edges after the edge that sampled the first event of the batch.
- R4: While no events are outstanding, no timer runs and `irq_o` does not rise, however long the idle period lasts.
- R5: A threshold of 0 or 1, or a budget of 0, gives one interrupt per event. `irq_o` rises on the edge that follows the edge sampling the event.
- R6: `irq_o` stays high until `ack_i` is sampled high. It is then low after that edge.
- R7: Events sampled while `irq_o` is high are counted toward the next batch. If that batch is already complete when acknowledged, `irq_o` is low for exactly one cycle and then high again.
- R8: Raising the interrupt restarts the count and the timer. An event sampled on the same edge becomes the first event of the new batch.
- R9: The outstanding count saturates at `2**CNT_W-1` and never wraps back to a small value.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | One event per high cycle |
| ack_i | input | 1 | Interrupt acknowledge |
| frame_thr_i | input | CNT_W | Event count that completes a batch |
| time_budget_i | input | TIME_W | Time budget in microsecond ticks |
| irq_o | output | 1 | Level interrupt, held until acknowledged |

## Verification
Directed patterns separate the two trigger paths. A burst of events in back-to-back cycles with a very long budget checks only the count path. A single event with a high threshold checks only the timer, with the rise checked on the exact edge. Further directed patterns cover the following cases:
- thresholds of 0 and 1 and a budget of 0, which must act as per-event mode;
- events during a pending interrupt, which show both that the next batch carries over and that the previous batch is cleared;
- an overfilled pending batch, which separates saturation from wrap-around.

Random event trains with random acknowledge delays, under random threshold pairs, then compare `irq_o` every cycle against a bench model. This catches any one-cycle shift in either path.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;

   // Width of a counter that must hold values 0 .. v-1 (never below 1 bit)
   function automatic int unsigned idx_w(input int unsigned v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/icm_prescaler.sv
module icm_prescaler #(
   parameter int unsigned TICK_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   import irq_coalesce_pkg::*;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("icm_prescaler: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_bypass
         // every running cycle is one tick
         assign tick_o = run_i;
      end else begin : g_divide
         localparam int unsigned PW = idx_w(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run_i || phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick_o = run_i && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/icm_budget_timer.sv
module icm_budget_timer #(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] budget_i,
   output logic [TIME_W-1:0] us_o,
   output logic              expired_o
);
   generate
      if (TIME_W < 2) begin : g_bad_w
         $error("icm_budget_timer: TIME_W must be at least 2");
      end
   endgenerate

   logic [TIME_W-1:0] us_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         us_q <= '0;
      end else if (clr_i) begin
         us_q <= '0;
      end else if (tick_i) begin
         us_q <= us_q + 1'b1;
      end
   end

   assign us_o      = us_q;
   assign expired_o = (us_q >= budget_i);
endmodule

// File: rtl/icm_event_counter.sv
module icm_event_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             evt_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("icm_event_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         // an event on the closing edge opens the next batch
         cnt_q <= {{(CNT_W-1){1'b0}}, evt_i};
      end else if (evt_i && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned TIME_W   = 16,
   parameter int unsigned TICK_DIV = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              ack_i,
   input  logic [CNT_W-1:0]  frame_thr_i,
   input  logic [TIME_W-1:0] time_budget_i,
   output logic              irq_o
);
   localparam logic [CNT_W-1:0] THR_MIN = CNT_W'(1);

   logic [CNT_W-1:0]  evt_cnt;
   logic [TIME_W-1:0] us_cnt;
   logic              expired;
   logic              tick;
   logic              armed;
   logic              batch_done;
   logic              fire;
   logic              irq_q;
   logic [CNT_W-1:0]  thr_eff;

   assign thr_eff    = (frame_thr_i == '0) ? THR_MIN : frame_thr_i;
   assign armed      = (evt_cnt != '0);
   assign batch_done = armed && ((evt_cnt >= thr_eff) || expired);
   assign fire       = batch_done && !irq_q;

   icm_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (fire),
      .evt_i     (evt_i),
      .cnt_o     (evt_cnt)
   );

   icm_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (armed && !expired && !fire),
      .tick_o (tick)
   );

   icm_budget_timer #(.TIME_W(TIME_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (fire || !armed),
      .tick_i    (tick),
      .budget_i  (time_budget_i),
      .us_o      (us_cnt),
      .expired_o (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (fire) begin
         irq_q <= 1'b1;
      end else if (ack_i) begin
         irq_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/icm_checker.sv
module icm_checker #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned TIME_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_i,
   input logic              ack_i,
   input logic              irq_o,
   input logic [CNT_W-1:0]  frame_thr_i,
   input logic [TIME_W-1:0] time_budget_i,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [TIME_W-1:0] us_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_count_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && cnt_q != '0 && (cnt_q >= frame_thr_i)) |=> irq_o);

   p_budget_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && cnt_q != '0 && us_q >= time_budget_i) |=> irq_o);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && cnt_q == '0) |=> !irq_o);

   p_idle_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (us_q == '0));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> irq_o);

   p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_i) |=> !irq_o);

   p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && evt_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (cnt_q <= CNT_W'(1) && us_q == '0));

   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && cnt_q != '0) |=> (cnt_q != '0));
endmodule

bind irq_coalesce icm_checker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .evt_i         (evt_i),
   .ack_i         (ack_i),
   .irq_o         (irq_o),
   .frame_thr_i   (frame_thr_i),
   .time_budget_i (time_budget_i),
   .cnt_q         (evt_cnt),
   .us_q          (us_cnt)
);

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
   localparam int CW  = 8;
   localparam int TW  = 16;
   localparam int DIV = 125;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt = 1'b0;
   logic          ack = 1'b0;
   logic [CW-1:0] thr = '0;
   logic [TW-1:0] bud = '0;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model state
   int m_cnt = 0, m_us = 0, m_pre = 0;
   bit m_irq = 1'b0;

   always #4 clk = ~clk;

   irq_coalesce #(.CNT_W(CW), .TIME_W(TW), .TICK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack),
      .frame_thr_i(thr), .time_budget_i(bud), .irq_o(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Expected behaviour per edge, from R2..R9
   function automatic bit batch_complete(int c, int u, int t, int b);
      int te = (t == 0) ? 1 : t;
      return (c != 0) && (c >= te || u >= b);
   endfunction

   task automatic model_edge(input bit e, input bit a);
      bit f = !m_irq && batch_complete(m_cnt, m_us, int'(thr), int'(bud));
      if (f || m_cnt == 0) begin
         m_pre = 0; m_us = 0;
      end else if (m_us < int'(bud)) begin
         if (m_pre == DIV - 1) begin m_pre = 0; m_us++; end
         else m_pre++;
      end else begin
         m_pre = 0;
      end
      if (f) m_cnt = e;
      else if (e && m_cnt < CMAX) m_cnt++;
      m_irq = f ? 1'b1 : (a ? 1'b0 : m_irq);
   endtask

   // one clock: drive at negedge, sample after the edge
   task automatic cyc(input bit e, input bit a, input bit cmp, input string req);
      @(negedge clk);
      evt = e; ack = a;
      @(posedge clk);
      model_edge(e, a);
      #1;
      if (cmp) check(req, int'(irq), int'(m_irq));
   endtask

   task automatic idle(input int n, input bit cmp, input string req);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, cmp, req);
   endtask

   task automatic do_ack();
      cyc(1'b0, 1'b1, 1'b1, "R6");
      check("R6 ack drop", int'(irq), 0);
   endtask

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset irq", int'(irq), 0);
      @(negedge clk); rst_n = 1'b1;

      // R1/R4: long idle never interrupts
      thr = 8'd4; bud = 16'd1;
      idle(600, 1'b1, "R4");
      check("R4 idle no irq", int'(irq), 0);

      // R2: four back-to-back events, budget effectively endless
      thr = 8'd4; bud = 16'd1000;
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, "R2");
      check("R2 not before next edge", int'(irq), 0);
      cyc(1'b0, 1'b0, 1'b1, "R2");
      check("R2 count fire", int'(irq), 1);
      // R6: held without ack
      idle(20, 1'b1, "R6");
      check("R6 held", int'(irq), 1);
      do_ack();

      // R3: one event, threshold not reached, budget 2 us
      thr = 8'd10; bud = 16'd2;
      cyc(1'b1, 1'b0, 1'b1, "R3");
      idle(2 * DIV, 1'b1, "R3");
      check("R3 not yet expired", int'(irq), 0);
      cyc(1'b0, 1'b0, 1'b1, "R3");
      check("R3 budget fire", int'(irq), 1);
      do_ack();

      // R5: per-event modes
      for (int mode = 0; mode < 3; mode++) begin
         thr = (mode == 0) ? 8'd0 : (mode == 1) ? 8'd1 : 8'd20;
         bud = (mode == 2) ? 16'd0 : 16'd1000;
         cyc(1'b1, 1'b0, 1'b1, "R5");
         check("R5 not on event edge", int'(irq), 0);
         cyc(1'b0, 1'b0, 1'b1, "R5");
         check("R5 per event", int'(irq), 1);
         do_ack();
      end

      // R7/R8: carry-over while pending, restart on fire
      thr = 8'd3; bud = 16'd1000;
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b0, 1'b1, "R8");
      check("R8 batch fire", int'(irq), 1);
      do_ack();
      // two events only: batch was restarted, no interrupt
      cyc(1'b1, 1'b0, 1'b1, "R8");
      cyc(1'b1, 1'b0, 1'b1, "R8");
      idle(50, 1'b1, "R8");
      check("R8 restarted count", int'(irq), 0);
      cyc(1'b1, 1'b0, 1'b1, "R8");
      cyc(1'b0, 1'b0, 1'b1, "R8");
      check("R8 third completes", int'(irq), 1);
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1, 1'b0, 1'b1, "R7");
         cyc(1'b0, 1'b0, 1'b1, "R7");
      end
      do_ack();
      cyc(1'b0, 1'b0, 1'b1, "R7");
      check("R7 carried batch refires", int'(irq), 1);
      do_ack();
      cyc(1'b0, 1'b0, 1'b1, "R7");
      check("R7 empty after refire", int'(irq), 0);

      // R9: overfill a pending batch, no wrap
      thr = 8'd200; bud = 16'd200;
      for (int i = 0; i < 200; i++) cyc(1'b1, 1'b0, 1'b1, "R9");
      cyc(1'b0, 1'b0, 1'b1, "R9");
      check("R9 first batch", int'(irq), 1);
      for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'b1, "R9");
      do_ack();
      cyc(1'b0, 1'b0, 1'b1, "R9");
      check("R9 saturated refire", int'(irq), 1);
      do_ack();

      // random trains against the model
      for (int r = 0; r < 8; r++) begin
         thr = 8'($urandom_range(0, 6));
         bud = 16'($urandom_range(0, 3));
         for (int i = 0; i < 2000; i++) begin
            bit e = ($urandom_range(0, 7) == 0);
            bit a = irq && ($urandom_range(0, 3) == 0);
            cyc(e, a, 1'b1, "R2/R3 random");
         end
         // drain: wait out the budget and acknowledge
         idle(5 * DIV, 1'b1, "R3 drain");
         if (irq) do_ack();
         idle(5 * DIV, 1'b1, "R3 drain");
         if (irq) do_ack();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule